// File: doc/BRIEF.md
# USB Host IN-Stage Retry Sequencer

This block runs the IN data stage of an endpoint-0 control transfer on the host side. Software arms it by setting a request bit. The sequencer then asks the packet layer to send an IN token and waits for the peripheral's reply. It sorts the reply into one of four kinds: stall, NAK, data packet, or no reply at all. Depending on the kind, it retries the token, completes the transfer, or stops with a sticky status flag and a one-cycle interrupt.

Two mechanisms bound the retries. A counter of consecutive silent attempts gives up after the third one. A NAK timer counts frame ticks from the first NAK of the transaction and compares them with a programmable limit. When that timer expires, the endpoint is halted. Software then chooses what happens next. If it clears the timeout flag while the request is still set, the sequencer resumes retrying. If it drops the request first and then clears the flag, the transaction is abandoned.

The packet layer is abstracted as a token strobe, an ACK strobe and a coded response strobe. Serial signalling, CRC and FIFO storage live elsewhere.

Top module: `usb_in_retry_seq`

## Requirements
- R1: A token is issued only while the request bit is set, the packet-ready flag is clear, the NAK-timeout flag is clear and no earlier token is still waiting for its response. Each attempt produces exactly one single-cycle `tok_send` pulse.
- R2: A STALL response (`rsp_kind` = 3'b001) sets `stall_seen`, clears `req_pkt`, zeroes `err_count` and pulses `irq`.
- R3: A DATA0 response (3'b011) or a DATA1 response (3'b100) pulses `ack_send`, sets `pkt_ready`, clears `req_pkt`, zeroes `err_count` and pulses `irq`. No further token is sent while `pkt_ready` is set.
- R4: A no-response code (3'b111, the timeout strobe) or any unlisted code increments `err_count`, and the token is retried. The third consecutive such attempt instead sets `err_flag`, clears `req_pkt`, returns `err_count` to 0 and pulses `irq`.
- R5: Any valid response (STALL, NAK or DATA) returns `err_count` to 0.
- R6: With a NAK limit of 0, a NAK (3'b010) always causes a retry. It never sets `nak_tmo` and never pulses `irq`.
- R7: With a nonzero limit L, the frame ticks that follow the first NAK of a transaction are counted. A NAK that arrives after at least L ticks sets `nak_tmo` and pulses `irq`, while `req_pkt` stays set. A NAK that arrives after L-1 ticks retries. No token is sent while `nak_tmo` is set.
- R8: Clearing `nak_tmo` while `req_pkt` is set resumes retrying. The NAK duration is then measured again from the next NAK.
- R9: Clearing `req_pkt` before clearing `nak_tmo` aborts the transaction, and no further token is sent.
- R10: After reset, all flags, the counter and all strobes are 0. Each status flag stays set until software writes a 1 to its bit of `cmd_flag_clr`: bit 0 clears `stall_seen`, bit 1 clears `err_flag`, bit 2 clears `nak_tmo` and bit 3 clears `pkt_ready`. `irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req_set | input | 1 | Software write: set the request bit |
| cmd_req_clr | input | 1 | Software write: clear the request bit (wins over set) |
| cmd_flag_clr | input | 4 | Write-one-to-clear for stall, error, NAK-timeout, packet-ready |
| lim_wr | input | 1 | Load the NAK limit register |
| lim_wdata | input | LIM_W | New NAK limit in frame ticks, 0 disables |
| tok_send | output | 1 | Pulse: send an IN token |
| ack_send | output | 1 | Pulse: send an ACK handshake |
| rsp_valid | input | 1 | A response code is presented |
| rsp_kind | input | 3 | Response code |
| frame_tick | input | 1 | One pulse per frame |
| req_pkt | output | 1 | Request bit |
| pkt_ready | output | 1 | A data packet has been received |
| stall_seen | output | 1 | STALL received |
| err_flag | output | 1 | Three silent attempts |
| nak_tmo | output | 1 | NAK limit expired, endpoint halted |
| err_count | output | ECW | Consecutive no-response count |
| nak_limit | output | LIM_W | NAK limit register value |
| irq | output | 1 | Interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle. These are: a token never follows a token directly, `irq` never lasts two cycles, no token leaves while halted or while a packet is pending, `err_count` stays below three, and stall or error detection leaves the request cleared. The bench scenarios are needed for the rest. They show the tick-count boundary of the NAK limit (expiry at L ticks but not at L-1) and the restart of the timer after a resume. They also show that resume and abort depend on the order of software writes, and that a NAK between silent attempts resets the error count.

// File: rtl/usb_in_retry_seq.sv
module usb_in_retry_seq #(
  parameter int LIM_W     = 8,
  parameter int ERR_LIMIT = 3,
  localparam int ECW      = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_req_set,
  input  logic             cmd_req_clr,
  input  logic [3:0]       cmd_flag_clr,
  input  logic             lim_wr,
  input  logic [LIM_W-1:0] lim_wdata,
  output logic             tok_send,
  output logic             ack_send,
  input  logic             rsp_valid,
  input  logic [2:0]       rsp_kind,
  input  logic             frame_tick,
  output logic             req_pkt,
  output logic             pkt_ready,
  output logic             stall_seen,
  output logic             err_flag,
  output logic             nak_tmo,
  output logic [ECW-1:0]   err_count,
  output logic [LIM_W-1:0] nak_limit,
  output logic             irq
);

  localparam logic [2:0] K_STALL = 3'b001;
  localparam logic [2:0] K_NAK   = 3'b010;
  localparam logic [2:0] K_DATA0 = 3'b011;
  localparam logic [2:0] K_DATA1 = 3'b100;

  logic             busy;
  logic             nak_run;
  logic [LIM_W-1:0] nak_elapsed;

  wire take      = busy && rsp_valid;
  wire is_stall  = take && rsp_kind == K_STALL;
  wire is_nak    = take && rsp_kind == K_NAK;
  wire is_data   = take && (rsp_kind == K_DATA0 || rsp_kind == K_DATA1);
  wire is_miss   = take && !is_stall && !is_nak && !is_data;
  wire [ECW-1:0] err_next = err_count + 1'b1;
  wire err_hit   = is_miss && err_next == ECW'(ERR_LIMIT);
  wire nak_exp   = is_nak && nak_limit != '0 && nak_run && nak_elapsed >= nak_limit;
  wire finish    = is_stall || is_data || err_hit;
  wire start     = !busy && req_pkt && !pkt_ready && !nak_tmo;
  wire resume    = cmd_flag_clr[2] && nak_tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tok_send <= 1'b0;
      ack_send <= 1'b0;
      irq      <= 1'b0;
    end else begin
      tok_send <= start;
      ack_send <= is_data;
      irq      <= finish || nak_exp;
      if (start)     busy <= 1'b1;
      else if (take) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pkt    <= 1'b0;
      pkt_ready  <= 1'b0;
      stall_seen <= 1'b0;
      err_flag   <= 1'b0;
      nak_tmo    <= 1'b0;
      nak_limit  <= '0;
    end else begin
      if (finish)           req_pkt <= 1'b0;
      else if (cmd_req_clr) req_pkt <= 1'b0;
      else if (cmd_req_set) req_pkt <= 1'b1;

      if (is_data)              pkt_ready <= 1'b1;
      else if (cmd_flag_clr[3]) pkt_ready <= 1'b0;

      if (is_stall)             stall_seen <= 1'b1;
      else if (cmd_flag_clr[0]) stall_seen <= 1'b0;

      if (err_hit)              err_flag <= 1'b1;
      else if (cmd_flag_clr[1]) err_flag <= 1'b0;

      if (nak_exp)              nak_tmo <= 1'b1;
      else if (cmd_flag_clr[2]) nak_tmo <= 1'b0;

      if (lim_wr) nak_limit <= lim_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_count <= '0;
    end else if (is_stall || is_nak || is_data || err_hit) begin
      err_count <= '0;
    end else if (is_miss) begin
      err_count <= err_next;
    end else if (cmd_req_clr) begin
      err_count <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || finish || cmd_req_clr || resume) begin
      nak_run     <= 1'b0;
      nak_elapsed <= '0;
    end else if (is_nak && !nak_run) begin
      nak_run     <= 1'b1;
      nak_elapsed <= '0;
    end else if (nak_run && frame_tick && nak_elapsed != '1) begin
      nak_elapsed <= nak_elapsed + 1'b1;
    end
  end

  AST_TOKEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tok_send |=> !tok_send); // R1
  AST_NO_TOKEN_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> !tok_send); // R3
  AST_ACK_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_send |-> pkt_ready && !req_pkt); // R3
  AST_STALL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_seen) |-> !req_pkt && err_count == '0); // R2
  AST_ERR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !req_pkt && err_count == '0); // R4
  AST_ERRCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_count < ECW'(ERR_LIMIT)); // R4
  AST_HALT_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    nak_tmo |-> !tok_send); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10

endmodule

// File: tb/tb_usb_in_retry_seq.sv
module tb_usb_in_retry_seq;
  localparam int LIM_W = 8;
  localparam logic [2:0] K_STALL = 3'b001, K_NAK = 3'b010, K_D0 = 3'b011,
                         K_D1 = 3'b100, K_TMO = 3'b111, K_ODD = 3'b000;

  logic clk = 0, rst_n = 0;
  logic cmd_req_set = 0, cmd_req_clr = 0, lim_wr = 0;
  logic [3:0] cmd_flag_clr = '0;
  logic [LIM_W-1:0] lim_wdata = '0;
  logic rsp_valid = 0, frame_tick = 0;
  logic [2:0] rsp_kind = '0;
  logic tok_send, ack_send, req_pkt, pkt_ready, stall_seen, err_flag, nak_tmo, irq;
  logic [1:0] err_count;
  logic [LIM_W-1:0] nak_limit;

  int n_run = 0, n_fail = 0;
  logic last_irq, last_ack;
  bit done = 0;

  always #5 clk = ~clk;

  usb_in_retry_seq #(.LIM_W(LIM_W), .ERR_LIMIT(3)) dut (
    .clk, .rst_n, .cmd_req_set, .cmd_req_clr, .cmd_flag_clr, .lim_wr, .lim_wdata,
    .tok_send, .ack_send, .rsp_valid, .rsp_kind, .frame_tick, .req_pkt, .pkt_ready,
    .stall_seen, .err_flag, .nak_tmo, .err_count, .nak_limit, .irq);

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic set_req();
    cmd_req_set = 1; step(); cmd_req_set = 0;
  endtask

  task automatic clr_req();
    cmd_req_clr = 1; step(); cmd_req_clr = 0;
  endtask

  task automatic clr_flag(input int b);
    cmd_flag_clr = 4'(1 << b); step(); cmd_flag_clr = '0;
  endtask

  task automatic set_limit(input int v);
    lim_wdata = LIM_W'(v); lim_wr = 1; step(); lim_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1; step(); frame_tick = 0; step();
    end
  endtask

  task automatic wait_tok(input string tag);
    int seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (tok_send) seen = 1; else step();
    end
    check({tag, " token issued"}, seen, 1);
  endtask

  task automatic count_tok(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (tok_send) n++;
    end
  endtask

  task automatic respond(input logic [2:0] k);
    rsp_kind = k; rsp_valid = 1; step(); rsp_valid = 0;
    last_irq = irq; last_ack = ack_send;
  endtask

  task automatic t_reset();
    check("R10 reset flags", {req_pkt, pkt_ready, stall_seen, err_flag, nak_tmo}, 0);
    check("R10 reset strobes", {tok_send, ack_send, irq}, 0);
    check("R10 reset count", err_count, 0);
  endtask

  task automatic t_idle();
    int n;
    count_tok(10, n);
    check("R1 no token without request", n, 0);
  endtask

  task automatic t_data();
    int n;
    set_req(); wait_tok("R3 d0"); respond(K_D0);
    check("R3 ack on DATA0", last_ack, 1);
    check("R3 irq on DATA0", last_irq, 1);
    check("R3 pkt_ready set, req cleared", {pkt_ready, req_pkt}, 2'b10);
    step();
    check("R10 irq single cycle", irq, 0);
    set_req(); count_tok(10, n);
    check("R1 no token while pkt_ready", n, 0);
    clr_flag(3); wait_tok("R1 after pkt_ready clear"); respond(K_D1);
    check("R3 ack on DATA1", last_ack, 1);
    repeat (5) step();
    check("R10 pkt_ready sticky", pkt_ready, 1);
    clr_flag(3);
    check("R10 pkt_ready cleared by write", pkt_ready, 0);
  endtask

  task automatic t_stall();
    set_req(); wait_tok("R2"); respond(K_STALL);
    check("R2 irq on stall", last_irq, 1);
    check("R2 stall flag, req cleared", {stall_seen, req_pkt}, 2'b10);
    check("R2 ack not sent", last_ack, 0);
    repeat (5) step();
    check("R10 stall sticky", stall_seen, 1);
    clr_flag(0);
    check("R10 stall cleared", stall_seen, 0);
  endtask

  task automatic t_errors();
    set_limit(0);
    set_req(); wait_tok("R4 a"); respond(K_TMO);
    check("R4 count after one miss", err_count, 1);
    check("R4 no irq on first miss", last_irq, 0);
    wait_tok("R4 retry"); respond(K_TMO);
    check("R4 count after two misses", err_count, 2);
    wait_tok("R5 b"); respond(K_NAK);
    check("R5 NAK clears count", err_count, 0);
    wait_tok("R4 c"); respond(K_TMO);
    wait_tok("R4 d"); respond(K_ODD);
    check("R4 odd code counted", err_count, 2);
    wait_tok("R4 e"); respond(K_TMO);
    check("R4 third miss irq", last_irq, 1);
    check("R4 err flag, req cleared", {err_flag, req_pkt}, 2'b10);
    check("R4 count back to zero", err_count, 0);
    clr_flag(1);
    check("R10 err flag cleared", err_flag, 0);
  endtask

  task automatic t_nak_unlimited();
    int irqs = 0;
    set_limit(0); set_req();
    for (int i = 0; i < 5; i++) begin
      wait_tok("R6 retry"); ticks(4); respond(K_NAK);
      irqs += int'(last_irq);
    end
    check("R6 no irq with limit 0", irqs, 0);
    check("R6 no timeout with limit 0", nak_tmo, 0);
    wait_tok("R6 still retrying"); respond(K_D0); clr_flag(3);
  endtask

  task automatic t_nak_limit();
    int n;
    set_limit(3);
    check("R7 limit register", nak_limit, 3);
    set_req(); wait_tok("R7 a"); respond(K_NAK);
    wait_tok("R7 b"); ticks(2); respond(K_NAK);
    check("R7 no expiry at L-1 ticks", {nak_tmo, last_irq}, 0);
    wait_tok("R7 c"); ticks(1); respond(K_NAK);
    check("R7 expiry at L ticks irq", last_irq, 1);
    check("R7 nak_tmo set, req kept", {nak_tmo, req_pkt}, 2'b11);
    count_tok(10, n);
    check("R7 halted: no token", n, 0);
    clr_flag(2);
    wait_tok("R8 resume");
    ticks(5); respond(K_NAK);
    check("R8 timer restarted on resume", nak_tmo, 0);
    wait_tok("R8 d"); ticks(3); respond(K_NAK);
    check("R8 expires again", {nak_tmo, last_irq}, 2'b11);
    clr_req(); clr_flag(2);
    count_tok(10, n);
    check("R9 abort: no token", n, 0);
    check("R9 abort: flags", {req_pkt, nak_tmo}, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset(); t_idle(); t_data(); t_stall(); t_errors();
    t_nak_unlimited(); t_nak_limit();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule